// File: doc/BRIEF.md
# Drift-Compensated Time-of-Day Counter

This block keeps a 64-bit time of day for stamping network packets. The value has two parts: a 32-bit seconds field and a 32-bit nanoseconds field. The nanoseconds field always stays below one billion. Everything runs from one reference clock.

The time moves forward in two ways.

- **Fine path.** A 32-bit phase accumulator adds a programmable 32-bit addend on every clock. Each carry out of the accumulator moves the time forward by a fixed 50 ns step. The addend therefore acts as a fractional frequency divider. An addend of 0xCCCCCCD0 on a 25 MHz reference gives an effective 20 MHz tick. Software can slew the rate gradually by rewriting the addend.
- **Coarse path.** This path is triggered by single-cycle strobes. A load strobe copies a staged seconds/nanoseconds value straight into the time. A correction strobe adds the staged offset to the time, or subtracts it, in one clock.

The staged values and the addend are set through a small write port. A snapshot strobe copies the whole 64-bit time into holding registers, so the seconds and nanoseconds read back belong to the same instant.

Top module: `tod_clock_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the time, the snapshot, the accumulator and the addend are all zero. With a zero addend the time does not move.
- R2: On each clock the accumulator adds the addend that was in effect before that edge. When the sum carries out of bit 31, the nanoseconds field rises by exactly 50 at that edge. With no load or correction strobe, the time either stays put or moves by exactly one 50 ns step per clock.
- R3: The nanoseconds field never reaches 1,000,000,000. When a step or a correction passes that value, the field wraps to the excess and the seconds field rises by one.
- R4: A clock with `init_stb` high loads the time with the staged seconds and the staged nanoseconds magnitude, ignoring the direction bit.
- R5: A clock with `corr_stb` high and the direction bit (`wr_data[31]`) clear adds the staged seconds and the staged nanoseconds magnitude to the time, with the R3 carry.
- R6: A clock with `corr_stb` high and the direction bit set subtracts the staged offset. If the nanoseconds would go negative, the block borrows one second and adds 1,000,000,000 to the nanoseconds.
- R7: A nanoseconds-stage write (`wr_sel`=1) stores bits 30:0 as the magnitude and bit 31 as the direction. If the magnitude is 1,000,000,000 or more, the write is dropped and the stage keeps its previous value.
- R8: If strobes arrive together, the load wins over the correction, and the correction wins over a fine step in the same clock. A fine step that loses is discarded.
- R9: An addend write (`wr_sel`=2) takes effect on the clock after the write edge. The accumulator keeps its fractional remainder across the change.
- R10: A clock with `snap_stb` high copies the time shown during that cycle into the snapshot outputs. The snapshot then holds until the next strobe.
- R11: With no load or correction strobe, the 64-bit time {seconds, nanoseconds} never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 seconds stage, 1 nanoseconds stage, 2 addend, 3 no target |
| wr_data | input | 32 | Write data |
| init_stb | input | 1 | Load time from stage |
| corr_stb | input | 1 | Apply staged offset to time |
| snap_stb | input | 1 | Capture time into snapshot |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 32 | Current nanoseconds |
| snap_sec | output | 32 | Captured seconds |
| snap_ns | output | 32 | Captured nanoseconds |

## Verification
The fine path is tried with three addends.

- **0x80000000** gives a carry on every second clock. Four clocks from a time of 999,999,923 ns separate a correct 50 ns step and a correct second rollover from an off-by-one wrap.
- **0xC0000000**, written while a remainder is pending, tells a design that applies the new addend one clock late from one that applies it at once. It also separates both from a design that clears the remainder on the change.
- **Zero** shows that the time holds still.

Coarse patterns then cover three cases:

- a nanoseconds sum that overflows;
- a subtraction that borrows;
- a load and a correction landing together, while a carry is pending in the same clock, which shows the priority order.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int SEC_W = 32;
    localparam int NS_W  = 32;
    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    typedef enum logic [1:0] {
        SEL_SEC    = 2'd0,
        SEL_NS     = 2'd1,
        SEL_ADDEND = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_TICK,
        ACT_CORR,
        ACT_INIT
    } tod_act_e;

    function automatic logic ns_in_range(input logic [NS_W-1:0] v);
        return v < NS_PER_SEC;
    endfunction

    // Normalised addition: both ns fields must already be below one second.
    function automatic tod_t tod_add(input tod_t a, input tod_t b);
        logic [NS_W:0] sum;
        tod_t r;
        sum = {1'b0, a.ns} + {1'b0, b.ns};
        if (sum >= {1'b0, NS_PER_SEC}) begin
            r.ns  = NS_W'(sum - {1'b0, NS_PER_SEC});
            r.sec = a.sec + b.sec + SEC_W'(1);
        end else begin
            r.ns  = NS_W'(sum);
            r.sec = a.sec + b.sec;
        end
        return r;
    endfunction

    // Normalised subtraction with a one-second borrow.
    function automatic tod_t tod_sub(input tod_t a, input tod_t b);
        tod_t r;
        if (a.ns >= b.ns) begin
            r.ns  = a.ns - b.ns;
            r.sec = a.sec - b.sec;
        end else begin
            r.ns  = a.ns + (NS_PER_SEC - b.ns);
            r.sec = a.sec - b.sec - SEC_W'(1);
        end
        return r;
    endfunction

    function automatic tod_t tod_step(input tod_t a, input logic [NS_W-1:0] inc);
        tod_t d;
        d.sec = '0;
        d.ns  = inc;
        return tod_add(a, d);
    endfunction

endpackage

// File: rtl/tod_upd_regs.sv
module tod_upd_regs
    import tod_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output tod_t              stage_val,
    output logic              stage_sub,
    output logic [ACC_W-1:0]  addend
);
    localparam int DIR_BIT = DATA_W - 1;

    wr_sel_e          sel;
    logic [NS_W-1:0]  ns_mag;
    logic             ns_ok;

    assign sel    = wr_sel_e'(wr_sel);
    assign ns_mag = NS_W'(wr_data[DIR_BIT-1:0]);
    assign ns_ok  = ns_in_range(ns_mag);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_val <= '0;
            stage_sub <= 1'b0;
            addend    <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_SEC:    stage_val.sec <= SEC_W'(wr_data);
                SEL_NS: begin
                    if (ns_ok) begin
                        stage_val.ns <= ns_mag;
                        stage_sub    <= wr_data[DIR_BIT];
                    end
                end
                SEL_ADDEND: addend <= ACC_W'(wr_data);
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] addend,
    output logic             carry
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, addend};
    assign carry = sum[ACC_W];

    // The accumulator always advances so its fraction survives strobes.
    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
    import tod_pkg::*;
#(
    parameter int TICK_NS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic init_stb,
    input  logic corr_stb,
    input  logic tick,
    input  tod_t stage_val,
    input  logic stage_sub,
    output tod_t tod_q
);
    localparam logic [NS_W-1:0] STEP = NS_W'(TICK_NS);

    tod_act_e act;
    tod_t     corr_val;
    tod_t     tod_d;

    always_comb begin
        if (init_stb)      act = ACT_INIT;
        else if (corr_stb) act = ACT_CORR;
        else if (tick)     act = ACT_TICK;
        else               act = ACT_HOLD;
    end

    always_comb begin
        if (stage_sub) corr_val = tod_sub(tod_q, stage_val);
        else           corr_val = tod_add(tod_q, stage_val);
    end

    always_comb begin
        unique case (act)
            ACT_INIT: tod_d = stage_val;
            ACT_CORR: tod_d = corr_val;
            ACT_TICK: tod_d = tod_step(tod_q, STEP);
            default:  tod_d = tod_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tod_q <= '0;
        else     tod_q <= tod_d;
    end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic snap_stb,
    input  tod_t tod_in,
    output tod_t snap_q
);
    always_ff @(posedge clk) begin
        if (rst)           snap_q <= '0;
        else if (snap_stb) snap_q <= tod_in;
    end
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
    import tod_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ACC_W   = 32,
    parameter int TICK_NS = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_stb,
    input  logic              corr_stb,
    input  logic              snap_stb,
    output logic [SEC_W-1:0]  time_sec,
    output logic [NS_W-1:0]   time_ns,
    output logic [SEC_W-1:0]  snap_sec,
    output logic [NS_W-1:0]   snap_ns
);
    tod_t             stage_val;
    logic             stage_sub;
    logic [ACC_W-1:0] addend;
    logic             tick;
    tod_t             tod_q;
    tod_t             snap_q;

    tod_upd_regs #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .stage_val (stage_val),
        .stage_sub (stage_sub),
        .addend    (addend)
    );

    tod_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .addend (addend),
        .carry  (tick)
    );

    tod_time_core #(.TICK_NS(TICK_NS)) u_core (
        .clk       (clk),
        .rst       (rst),
        .init_stb  (init_stb),
        .corr_stb  (corr_stb),
        .tick      (tick),
        .stage_val (stage_val),
        .stage_sub (stage_sub),
        .tod_q     (tod_q)
    );

    tod_snapshot u_snap (
        .clk      (clk),
        .rst      (rst),
        .snap_stb (snap_stb),
        .tod_in   (tod_q),
        .snap_q   (snap_q)
    );

    assign time_sec = tod_q.sec;
    assign time_ns  = tod_q.ns;
    assign snap_sec = snap_q.sec;
    assign snap_ns  = snap_q.ns;
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
    import tod_pkg::*;
#(
    parameter int TICK_NS = 50
) (
    input logic             clk,
    input logic             rst,
    input logic             init_stb,
    input logic             corr_stb,
    input logic             snap_stb,
    input logic [SEC_W-1:0] time_sec,
    input logic [NS_W-1:0]  time_ns,
    input logic [SEC_W-1:0] snap_sec,
    input logic [NS_W-1:0]  snap_ns,
    input tod_t             stage_val
);
    localparam logic [NS_W-1:0] STEP = NS_W'(TICK_NS);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (time_sec == '0 && time_ns == '0 && snap_sec == '0 && snap_ns == '0));

    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!init_stb && !corr_stb) |=>
            ((time_sec == $past(time_sec)) &&
             ((time_ns == $past(time_ns)) || (time_ns == $past(time_ns) + STEP))) ||
            ((time_sec == $past(time_sec) + SEC_W'(1)) &&
             (time_ns + NS_PER_SEC == $past(time_ns) + STEP)));

    p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
        time_ns < NS_PER_SEC);

    p_init_load_r4: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (time_sec == $past(stage_val.sec) && time_ns == $past(stage_val.ns)));

    p_stage_valid_r7: assert property (@(posedge clk) disable iff (rst)
        stage_val.ns < NS_PER_SEC);

    p_snap_capture_r10: assert property (@(posedge clk) disable iff (rst)
        snap_stb |=> (snap_sec == $past(time_sec) && snap_ns == $past(time_ns)));

    p_snap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !snap_stb |=> ($stable(snap_sec) && $stable(snap_ns)));

    p_monotonic_r11: assert property (@(posedge clk) disable iff (rst)
        (!init_stb && !corr_stb) |=> ({time_sec, time_ns} >= $past({time_sec, time_ns})));
endmodule

bind tod_clock_core tod_clock_checker #(.TICK_NS(TICK_NS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_stb  (init_stb),
    .corr_stb  (corr_stb),
    .snap_stb  (snap_stb),
    .time_sec  (time_sec),
    .time_ns   (time_ns),
    .snap_sec  (snap_sec),
    .snap_ns   (snap_ns),
    .stage_val (stage_val)
);

// File: tb/tod_clock_core_tb_top.sv
module tod_clock_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        init_stb = 1'b0;
    logic        corr_stb = 1'b0;
    logic        snap_stb = 1'b0;
    logic [31:0] time_sec, time_ns, snap_sec, snap_ns;

    typedef struct {
        bit          is_snap;
        logic [31:0] sec;
        logic [31:0] ns;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    tod_clock_core dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .init_stb (init_stb),
        .corr_stb (corr_stb),
        .snap_stb (snap_stb),
        .time_sec (time_sec),
        .time_ns  (time_ns),
        .snap_sec (snap_sec),
        .snap_ns  (snap_ns)
    );

    // Monitor: compares queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [31:0] as, an;
                e  = exp_q.pop_front();
                as = e.is_snap ? snap_sec : time_sec;
                an = e.is_snap ? snap_ns  : time_ns;
                n_checks++;
                if (as !== e.sec || an !== e.ns) begin
                    n_fail++;
                    $display("FAIL %s actual=%0d/%0d expected=%0d/%0d", e.tag, as, an, e.sec, e.ns);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic expect_time(input logic [31:0] s, input logic [31:0] n, input string tag);
        exp_t e;
        e.is_snap = 1'b0; e.sec = s; e.ns = n; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic expect_snap(input logic [31:0] s, input logic [31:0] n, input string tag);
        exp_t e;
        e.is_snap = 1'b1; e.sec = s; e.ns = n; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        step();
        repeat (3) step();
        expect_time(0, 0, "R1 time during reset");
        rst = 1'b0;
        step();
        expect_time(0, 0, "R1 time after reset");
        expect_snap(0, 0, "R1 snapshot after reset");
        repeat (3) step();
        expect_time(0, 0, "R1 zero addend holds");

        // R4 load
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd123);
        init_stb = 1'b1; step(); init_stb = 1'b0;
        expect_time(5, 123, "R4 load");

        // R7 out-of-range nanoseconds dropped
        wr(2'd1, 32'd1_000_000_000);
        init_stb = 1'b1; step(); init_stb = 1'b0;
        expect_time(5, 123, "R7 invalid ns ignored");

        // R5 add with carry
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd999_999_900);
        corr_stb = 1'b1; step(); corr_stb = 1'b0;
        expect_time(8, 23, "R5 add with carry");

        // R6 subtract with borrow
        wr(2'd0, 32'd1);
        wr(2'd1, {1'b1, 31'd100});
        corr_stb = 1'b1; step(); corr_stb = 1'b0;
        expect_time(6, 999_999_923, "R6 subtract borrow");

        // R2 / R3 fine stepping with half-rate addend
        wr(2'd2, 32'h8000_0000);
        step();
        expect_time(6, 999_999_923, "R2 no carry yet");
        step();
        expect_time(6, 999_999_973, "R2 first carry");
        step(); step();
        expect_time(7, 23, "R3 ns wrap to seconds");

        // R9 addend change timing and remainder
        wr(2'd2, 32'hC000_0000);
        expect_time(7, 23, "R9 old addend at write edge");
        step();
        expect_time(7, 73, "R9 remainder kept");
        step(); step();
        expect_time(7, 123, "R9 new addend one clock late");

        // R8 priority
        wr(2'd0, 32'd10);
        wr(2'd1, 32'd500);
        init_stb = 1'b1; corr_stb = 1'b1; step(); init_stb = 1'b0; corr_stb = 1'b0;
        expect_time(10, 500, "R8 load beats correction and step");
        step(); step();
        expect_time(10, 550, "R2 stepping resumes");
        corr_stb = 1'b1; step(); corr_stb = 1'b0;
        expect_time(20, 1050, "R8 correction beats step");

        // R10 snapshot
        snap_stb = 1'b1; step(); snap_stb = 1'b0;
        expect_time(20, 1100, "R10 time at snapshot edge");
        expect_snap(20, 1050, "R10 snapshot captures");
        step(); step();
        expect_snap(20, 1050, "R10 snapshot holds");
        expect_time(20, 1150, "R11 time keeps rising");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule